// File: doc/BRIEF.md
# Clock Output Enable Controller

This block decides, for each of a set of clock output pins, whether the pin driver is active or left floating. Three pins steer it. The first is an active-high global override that floats every output. The other two are shared enable lines, called X and Y. Each output also has a small stored mode that ties it to one of these sources.

The modes are stored in flops and loaded one output at a time through a simple write port. The write port carries a strobe, an output index and a 2-bit mode. The drive decision is combinational from the pins and the stored modes, so a pin change takes effect at once. A tri-state model of each pad passes the output's clock level while it is enabled and floats otherwise.

Top module: `clkout_oe_ctrl`

## Requirements
- R1: While `glob_hiz` is 1, every bit of `drv_en` is 0 and every pad floats, whatever the stored modes hold.
- R2: With `glob_hiz` at 0, an output whose mode is 2'b00 (always on) has `drv_en` at 1 for any level of `en_x` and `en_y`.
- R3: An output whose mode is 2'b01 (always off) has `drv_en` at 0 for any pin levels.
- R4: With `glob_hiz` at 0, an output whose mode is 2'b10 has `drv_en` equal to `en_x`.
- R5: With `glob_hiz` at 0, an output whose mode is 2'b11 has `drv_en` equal to `en_y`.
- R6: After a synchronous reset, every stored mode is 2'b01, so no output drives until it is configured.
- R7: A rising clock edge with `cfg_wr` at 1 stores `cfg_mode` into the mode of output `cfg_idx` only. The new mode shows in `drv_en` after that edge. With `cfg_wr` at 0, no mode changes.
- R8: A write whose `cfg_idx` is N or more changes no stored mode.
- R9: `drv_en` follows changes on `glob_hiz`, `en_x` and `en_y` in the same cycle, with no clock edge in between.
- R10: While `drv_en[k]` is 1, `pad_out[k]` equals `clk_src[k]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the mode registers |
| rst_n | input | 1 | Synchronous active-low reset |
| glob_hiz | input | 1 | Active-high override that floats all outputs |
| en_x | input | 1 | Shared enable line X |
| en_y | input | 1 | Shared enable line Y |
| cfg_wr | input | 1 | Mode write strobe |
| cfg_idx | input | IDX_W | Output index addressed by a write |
| cfg_mode | input | 2 | Mode value to store |
| clk_src | input | N | Clock level for each output |
| drv_en | output | N | Per-output driver enable |
| pad_out | output | N | Tri-state pad model |

## Verification
The assertions take the pins and write port to be sampled at the clock edge. They expect the mode registers to change only through a strobed write, so a stored mode is stable between writes. The stimulus keeps to this by changing `glob_hiz`, `en_x`, `en_y` and the write fields away from the rising edge, and by raising `cfg_wr` for exactly one edge per write. Out-of-range indices are driven only on strobed writes, so the assertion that such a write changes nothing is exercised directly. Same-cycle response is checked between edges, where no register can have moved.

// File: rtl/oe_ctrl_pkg.sv
// Shared types for the clock output enable controller.
// Assumes a 2-bit per-output mode; the encoding is fixed by the write port.
package oe_ctrl_pkg;

    typedef enum logic [1:0] {
        MODE_ON  = 2'b00,
        MODE_OFF = 2'b01,
        MODE_X   = 2'b10,
        MODE_Y   = 2'b11
    } drive_mode_e;

endpackage

// File: rtl/oe_cfg_bank.sv
// Mode register bank: one 2-bit mode per output, written one at a time.
// Assumes cfg_idx is meaningful only while cfg_wr is high; out-of-range
// indices match no register and are dropped.
module oe_cfg_bank
    import oe_ctrl_pkg::*;
#(
    parameter int N     = 6,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_wr,
    input  logic [IDX_W-1:0]      cfg_idx,
    input  drive_mode_e           cfg_mode,
    output drive_mode_e [N-1:0]   mode_q
);

    for (genvar k = 0; k < N; k++) begin : g_reg
        logic hit;
        // Address decode for this output's register.
        always_comb hit = cfg_wr && (cfg_idx == IDX_W'(k));

        // Hold the mode; reset to off, load on an addressed write.
        always_ff @(posedge clk) begin
            if (!rst_n)   mode_q[k] <= MODE_OFF;
            else if (hit) mode_q[k] <= cfg_mode;
        end

        assert_reset_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(rst_n) |-> mode_q[k] == MODE_OFF);

        assert_write_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_wr && cfg_idx == IDX_W'(k)) |=> mode_q[k] == $past(cfg_mode));

        assert_no_write_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !(cfg_wr && cfg_idx == IDX_W'(k)) |=> $stable(mode_q[k]));
    end

    assert_bad_index_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && int'(cfg_idx) >= N) |=> $stable(mode_q));

endmodule

// File: rtl/oe_mode_decode.sv
// Drive decision for one output from its mode and the shared pins.
// Purely combinational; assumes the global override is active high.
module oe_mode_decode
    import oe_ctrl_pkg::*;
(
    input  drive_mode_e mode,
    input  logic        glob_hiz,
    input  logic        en_x,
    input  logic        en_y,
    output logic        drv_en
);

    // Select the enable source, then let the override win.
    always_comb begin
        unique case (mode)
            MODE_ON:  drv_en = 1'b1;
            MODE_OFF: drv_en = 1'b0;
            MODE_X:   drv_en = en_x;
            MODE_Y:   drv_en = en_y;
            default:  drv_en = 1'b0;
        endcase
        if (glob_hiz) drv_en = 1'b0;
    end

endmodule

// File: rtl/oe_pad_model.sv
// Tri-state model of the output pads: pass the clock level when enabled,
// float otherwise. Assumes one enable bit per pad.
module oe_pad_model #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] drv_en,
    input  logic [N-1:0] clk_src,
    output wire  [N-1:0] pad_out
);

    for (genvar k = 0; k < N; k++) begin : g_pad
        // Driver or high impedance for this pad.
        assign pad_out[k] = drv_en[k] ? clk_src[k] : 1'bz;

        assert_pad_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
            drv_en[k] |-> pad_out[k] == clk_src[k]);
    end

endmodule

// File: rtl/clkout_oe_ctrl.sv
// Clock output enable controller top: mode registers, per-output decode
// and pad model. Assumes pins are synchronous to clk for the checks only;
// the drive path itself has no register.
module clkout_oe_ctrl
    import oe_ctrl_pkg::*;
#(
    parameter int N     = 6,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             glob_hiz,
    input  logic             en_x,
    input  logic             en_y,
    input  logic             cfg_wr,
    input  logic [IDX_W-1:0] cfg_idx,
    input  logic [1:0]       cfg_mode,
    input  logic [N-1:0]     clk_src,
    output logic [N-1:0]     drv_en,
    output wire  [N-1:0]     pad_out
);

    drive_mode_e [N-1:0] mode_q;
    drive_mode_e         wr_mode;

    // Cast the raw write value into the mode type.
    always_comb wr_mode = drive_mode_e'(cfg_mode);

    oe_cfg_bank #(.N(N), .IDX_W(IDX_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_wr   (cfg_wr),
        .cfg_idx  (cfg_idx),
        .cfg_mode (wr_mode),
        .mode_q   (mode_q)
    );

    for (genvar k = 0; k < N; k++) begin : g_dec
        oe_mode_decode u_dec (
            .mode     (mode_q[k]),
            .glob_hiz (glob_hiz),
            .en_x     (en_x),
            .en_y     (en_y),
            .drv_en   (drv_en[k])
        );

        assert_glob_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
            glob_hiz |-> !drv_en[k]);

        assert_mode_on_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (!glob_hiz && mode_q[k] == MODE_ON) |-> drv_en[k]);

        assert_mode_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_q[k] == MODE_OFF) |-> !drv_en[k]);

        assert_mode_x_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (!glob_hiz && mode_q[k] == MODE_X) |-> drv_en[k] == en_x);

        assert_mode_y_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (!glob_hiz && mode_q[k] == MODE_Y) |-> drv_en[k] == en_y);
    end

    oe_pad_model #(.N(N)) u_pad (
        .clk     (clk),
        .rst_n   (rst_n),
        .drv_en  (drv_en),
        .clk_src (clk_src),
        .pad_out (pad_out)
    );

endmodule

// File: tb/sim_clkout_oe_ctrl.sv
// Bench: table of pin patterns against a fixed mode set, then directed tests.
module sim_clkout_oe_ctrl;

    localparam int N     = 6;
    localparam int IDX_W = 3;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             glob_hiz, en_x, en_y, cfg_wr;
    logic [IDX_W-1:0] cfg_idx;
    logic [1:0]       cfg_mode;
    logic [N-1:0]     clk_src;
    logic [N-1:0]     drv_en;
    wire  [N-1:0]     pad_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    clkout_oe_ctrl #(.N(N), .IDX_W(IDX_W)) u0 (
        .clk(clk), .rst_n(rst_n), .glob_hiz(glob_hiz), .en_x(en_x), .en_y(en_y),
        .cfg_wr(cfg_wr), .cfg_idx(cfg_idx), .cfg_mode(cfg_mode),
        .clk_src(clk_src), .drv_en(drv_en), .pad_out(pad_out)
    );

    // Modes used by the table: out0 on, out1 off, out2 X, out3 Y, out4 X, out5 Y.
    // Entry = {glob_hiz, en_x, en_y, expected drv_en[5:0]}.
    localparam logic [8:0] VEC [8] = '{
        {3'b000, 6'h01}, {3'b010, 6'h15}, {3'b001, 6'h29}, {3'b011, 6'h3D},
        {3'b100, 6'h00}, {3'b110, 6'h00}, {3'b101, 6'h00}, {3'b111, 6'h00}
    };

    task automatic check(input string req, input logic [N-1:0] got, input logic [N-1:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    task automatic wr(input int idx, input logic [1:0] m);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_idx = IDX_W'(idx); cfg_mode = m;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; glob_hiz = 1'b0; en_x = 1'b1; en_y = 1'b1;
        cfg_wr = 1'b0; cfg_idx = '0; cfg_mode = 2'b00; clk_src = 6'b101101;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R6: all modes off after reset even with both enables high.
        check("R6 reset all off", drv_en, 6'h00);

        wr(0, 2'b00); wr(1, 2'b01); wr(2, 2'b10);
        wr(3, 2'b11); wr(4, 2'b10); wr(5, 2'b11);

        // Table walk: R1 override, R2 on, R3 off, R4 X, R5 Y.
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            {glob_hiz, en_x, en_y} = VEC[i][8:6];
            #1;
            check("R1-override/R2 on/R3 off/R4 X/R5 Y table", drv_en, VEC[i][5:0]);
        end

        // R10: enabled pads carry the clock level.
        @(negedge clk);
        glob_hiz = 1'b0; en_x = 1'b1; en_y = 1'b1;
        #1;
        check("R10 pad level", pad_out & drv_en, clk_src & drv_en);
        clk_src = 6'b010010;
        #1;
        check("R10 pad level toggled", pad_out & drv_en, clk_src & drv_en);

        // R9: change pins between edges; response without a clock edge.
        @(posedge clk); #1;
        en_x = 1'b0; #0.5;
        check("R9 same-cycle X drop", drv_en, 6'h29);
        glob_hiz = 1'b1; #0.5;
        check("R9 same-cycle override", drv_en, 6'h00);
        glob_hiz = 1'b0;

        // R7: write out1 to on; only out1 changes, after the edge.
        en_x = 1'b0; en_y = 1'b0;
        @(negedge clk);
        cfg_wr = 1'b1; cfg_idx = 3'd1; cfg_mode = 2'b00;
        #0.5;
        check("R7 before edge", drv_en, 6'h01);
        @(negedge clk);
        cfg_wr = 1'b0;
        check("R7 after write", drv_en, 6'h03);

        // R7: strobe low does nothing.
        @(negedge clk);
        cfg_idx = 3'd3; cfg_mode = 2'b00;
        @(negedge clk);
        check("R7 no strobe", drv_en, 6'h03);

        // R8: out-of-range indices 6 and 7 change nothing.
        wr(6, 2'b00);
        wr(7, 2'b00);
        check("R8 bad index", drv_en, 6'h03);
        en_x = 1'b1; en_y = 1'b1; #1;
        check("R8 modes kept", drv_en, 6'h3F);

        // R3: set out5 off; stays off under both enables.
        wr(5, 2'b01);
        check("R3 off after write", drv_en, 6'h1F);

        // R6: reset mid-run returns every output to off.
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check("R6 reset again", drv_en, 6'h00);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule